// File: doc/BRIEF.md
# Presettable Synchronous Counter with Split Enables

This block is a small up-counter for building wider counters out of identical stages. A parameter sets each stage to run as a plain binary counter, which wraps after its largest value, or as a decade counter, which wraps after nine. The stage can be cleared or loaded with a parallel value. Counting needs two enables that are ANDed together. One enable takes part in the carry-out. The other gates only the local count.

To build a wider counter, connect each stage's carry-out to the carry-side enable of the next stage up. All stages share the clock and the plain enable. The carry then ripples through combinational AND gates, and every stage changes state on the same clock edge. A second parameter sets the clear to act on the clock edge or at once.

Top module: `sync_preset_counter`

## Requirements
- R1: In binary mode, with both enables high and clear and load inactive, the count rises by one on each rising clock edge, and the largest value 2^WIDTH-1 (15 for 4 bits) is followed by 0.
- R2: With ASYNC_CLR=0, `clr_n` low at a rising edge makes the count 0 on that edge, whatever the load, data and enables are. While no edge arrives, the count does not change.
- R3: With ASYNC_CLR=1, `clr_n` going low makes the count 0 without waiting for a clock edge. The count stays 0 across edges while `clr_n` is low.
- R4: With clear inactive, `load_n` low at a rising edge copies `din` into the count on that edge, whatever the enables are.
- R5: With clear and load inactive, the count keeps its value across an edge if `en_p` or `en_t` is low.
- R6: `carry_out` is high exactly when `en_t` is high and the count equals the terminal value: 2^WIDTH-1 in binary mode, 9 in decade mode. `carry_out` does not depend on `en_p`, and it follows its inputs without a clock edge.
- R7: In decade mode, an enabled count from any value 0 to 9 moves to the next value, and 9 is followed directly by 0. A count that starts in 0..9 never reaches 10..15.
- R8: In decade mode, a value above 9 that was loaded rises by one per enabled edge up to 15 and then becomes 0, with `carry_out` low along the way.
- R9: Two stages joined lower `carry_out` to upper `en_t`, sharing the clock and `en_p`, count as one 8-bit binary counter (0..255) or one two-digit decade counter (0..99), and wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Clear, active low; acts on the edge or at once, set by ASYNC_CLR |
| load_n | input | 1 | Parallel load, active low, acts on the edge |
| din | input | WIDTH | Value to load |
| en_p | input | 1 | Count enable that affects the local count only |
| en_t | input | 1 | Count enable that also gates carry_out |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | High when en_t is high and the count is at its terminal value |

## Verification
The bench runs a binary pair with edge-acting clear next to a decade pair with immediate clear, and drives both from the same controls. A long run with every enable held high separates correct carry chaining from an upper stage that moves early or late, since that stage must step only at the lower stage's wrap. Directed loads above nine in decade mode show whether the wrap is decoded from the full count or only from the terminal value. Random mixes of clear, load and the two enables test the order of precedence. They also test that en_p never affects the carry. Checks made between edges with clear low tell the immediate clear apart from the edge-acting one.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } cnt_op_e;

  function automatic int unsigned term_value(input int unsigned width, input bit decade);
    return decade ? 9 : ((1 << width) - 1);
  endfunction
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
#(
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);
  // precedence: clear, then load, then count, else hold
  generate
    if (SYNC_CLR) begin : g_sync
      always_comb begin
        if (!clr_n)              op = OP_CLEAR;
        else if (!load_n)        op = OP_LOAD;
        else if (en_p && en_t)   op = OP_COUNT;
        else                     op = OP_HOLD;
      end
    end else begin : g_async
      logic unused_clr;
      assign unused_clr = clr_n;
      always_comb begin
        if (!load_n)             op = OP_LOAD;
        else if (en_p && en_t)   op = OP_COUNT;
        else                     op = OP_HOLD;
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_term_decode.sv
module cnt_term_decode #(
  parameter int          WIDTH = 4,
  parameter int unsigned TERM  = 15
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             at_term,
  output logic             carry
);
  localparam logic [WIDTH-1:0] TERM_W = WIDTH'(TERM);
  assign at_term = (q == TERM_W);
  assign carry   = en_t & at_term;
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  input  logic             at_term,
  output logic [WIDTH-1:0] nxt
);
  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = at_term ? '0 : q + WIDTH'(1);
      default:  nxt = q;
    endcase
  end
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  localparam int unsigned      TERM   = term_value(WIDTH, DECADE);
  localparam logic [WIDTH-1:0] TERM_W = WIDTH'(TERM);

  cnt_op_e          op;
  logic             at_term;
  logic [WIDTH-1:0] nxt;

  cnt_ctrl #(.SYNC_CLR(!ASYNC_CLR)) u_ctrl (
    .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t), .op(op)
  );

  cnt_term_decode #(.WIDTH(WIDTH), .TERM(TERM)) u_term (
    .q(q), .en_t(en_t), .at_term(at_term), .carry(carry_out)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .op(op), .q(q), .din(din), .at_term(at_term), .nxt(nxt)
  );

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  generate
    if (ASYNC_CLR) begin : g_aclr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
      assert_async_clear_R3: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |-> (q == '0));
    end else begin : g_sclr
      always_ff @(posedge clk) q <= nxt;
      assert_sync_clear_R2: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (q == '0));
    end
    if (DECADE) begin : g_dec
      assert_decade_range_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && q <= TERM_W) |=> (q <= TERM_W));
    end
  endgenerate

  assert_load_R4: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> (q == $past(din)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (carry_out && en_p && load_n) |=> (q == '0));
  assert_carry_gate_R6: assert property (@(posedge clk) disable iff (!armed)
    !en_t |-> !carry_out);
endmodule

// File: tb/sync_preset_counter_test.sv
module sync_preset_counter_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din_lo = '0, din_hi = '0;
  logic [3:0] bq_lo, bq_hi, dq_lo, dq_hi;
  logic bc_lo, bc_hi, dc_lo, dc_hi;

  // binary pair, edge-acting clear
  sync_preset_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_lo),
    .en_p(en_p), .en_t(en_t), .q(bq_lo), .carry_out(bc_lo));
  sync_preset_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) uut_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_hi),
    .en_p(en_p), .en_t(bc_lo), .q(bq_hi), .carry_out(bc_hi));
  // decade pair, immediate clear
  sync_preset_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) dec_lo (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_lo),
    .en_p(en_p), .en_t(en_t), .q(dq_lo), .carry_out(dc_lo));
  sync_preset_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) dec_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_hi),
    .en_p(en_p), .en_t(dc_lo), .q(dq_hi), .carry_out(dc_hi));

  int vectors = 0, misses = 0;
  bit done = 1'b0;
  logic [3:0] m_blo = '0, m_bhi = '0, m_dlo = '0, m_dhi = '0;

  function automatic logic [3:0] model_next(input logic [3:0] cur, input logic c, l, p, t,
                                            input logic [3:0] d, input logic [3:0] term);
    if (!c) return 4'd0;
    if (!l) return d;
    if (p && t) return (cur == term) ? 4'd0 : cur + 4'd1;
    return cur;
  endfunction

  function automatic string op_tag(input logic c, l, p, t, input bit dec);
    if (!c) return dec ? "R3" : "R2";
    if (!l) return "R4";
    if (p && t) return dec ? "R7" : "R1";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  string tag_b, tag_d;

  task automatic step(input logic c, l, p, t, input logic [3:0] dl, dh);
    logic eb_lo, eb_hi, ed_lo, ed_hi;
    clr_n = c; load_n = l; en_p = p; en_t = t; din_lo = dl; din_hi = dh;
    tag_b = op_tag(c, l, p, t, 1'b0);
    tag_d = op_tag(c, l, p, t, 1'b1);
    #1;
    if (!c) begin m_dlo = '0; m_dhi = '0; end
    check("R3", dq_lo, m_dlo);            // immediate clear, before any edge
    check("R2", bq_lo, m_blo);            // edge-acting clear: no change yet
    eb_lo = t && (m_blo == 4'd15);
    eb_hi = eb_lo && (m_bhi == 4'd15);
    ed_lo = t && (m_dlo == 4'd9);
    ed_hi = ed_lo && (m_dhi == 4'd9);
    check("R6", {3'b0, bc_lo}, {3'b0, eb_lo});
    check("R6", {3'b0, bc_hi}, {3'b0, eb_hi});
    check("R6", {3'b0, dc_lo}, {3'b0, ed_lo});
    check("R6", {3'b0, dc_hi}, {3'b0, ed_hi});
    m_bhi = model_next(m_bhi, c, l, p, eb_lo, dh, 4'd15);
    m_blo = model_next(m_blo, c, l, p, t, dl, 4'd15);
    m_dhi = model_next(m_dhi, c, l, p, ed_lo, dh, 4'd9);
    m_dlo = model_next(m_dlo, c, l, p, t, dl, 4'd9);
    @(negedge clk);
    check(tag_b, bq_lo, m_blo);
    check("R9", bq_hi, m_bhi);
    check(tag_d, dq_lo, m_dlo);
    check("R9", dq_hi, m_dhi);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    check("R2", bq_lo, 4'd0); check("R2", bq_hi, 4'd0);
    check("R3", dq_lo, 4'd0); check("R3", dq_hi, 4'd0);
    // free count through full 8-bit wrap (R1, R7, R9)
    for (int i = 0; i < 260; i++) step(1, 1, 1, 1, 4'd0, 4'd0);
    check("R9", {bq_hi[3:0]}, 4'd0);
    // en_p low holds but carry still follows en_t (R5, R6)
    step(1, 0, 1, 1, 4'd15, 4'd9);
    step(1, 1, 0, 1, 4'd0, 4'd0);
    step(1, 1, 1, 0, 4'd0, 4'd0);
    // decade value above nine (R8)
    step(1, 0, 0, 0, 4'd12, 4'd0);
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 4'd0, 4'd0);
    check("R8", dq_lo, 4'd0);
    check("R8", dq_hi, 4'd0);
    // clear beats load (R2, R3)
    step(0, 0, 1, 1, 4'd5, 4'd5);
    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 40) != 0, ($urandom % 12) != 0, ($urandom % 5) != 0,
           ($urandom % 5) != 0, 4'($urandom), 4'($urandom));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule